// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits between two independent memory ports, left and right, that share one storage array. Each port presents a select, a write strobe and an address in every cycle. When both ports are selected at the same address, the arbiter names one port the owner of that location. It blocks the write of the other port in the same cycle. One cycle later it drives an active-low busy flag to the losing port. The owner is the port that arrived first. A port arrives when its select rises or its address changes. Two kinds of collision follow from this. In the first, one port moves its address onto a location the other port already holds. In the second, one port turns on its select while its address already matches the other port.

A parameter sets master or slave behaviour when the block is built. In master mode the block arbitrates and drives the busy outputs. In slave mode the block does no arbitration. It takes busy as an input for each port and holds off that port's write while the input is low. Its own busy outputs stay inactive. This lets several blocks share one arbitration decision. In both modes a read is never held back.

Top module: `dp_collide_arb`

## Requirements
- R1: Reset (active-low, asynchronous) drives both busy outputs high (inactive) at once and clears any ownership. With no port selected, no write grant is given.
- R2: In master mode, when both ports are selected at equal addresses, exactly one port loses. The losing port's write grant is low in that same cycle, and the other port's write grant follows its write strobe.
- R3: Address trigger. If one port keeps its select and address from the previous cycle and the other port changes its address onto the same location, the port that changed its address loses.
- R4: Enable trigger. If one port keeps its select and address from the previous cycle and the other port raises its select at the same address, the port that raised its select loses.
- R5: The owner stays the same for as long as the collision lasts. A losing port that begins to write later in the collision is still blocked.
- R6: busy_x_n goes low in the cycle after port x loses. It goes high again in the cycle after the collision ends, that is, after the addresses differ or either port deselects. The two busy outputs are never low together.
- R7: If both ports arrive in the same cycle, exactly one side wins. Which side wins is not promised.
- R8: A read (select high, write strobe low) always gets a read grant, on a losing port as well. The read grant is low whenever the write strobe is high.
- R9: In slave mode, a low busy_in_x_n blocks port x's write grant until the input returns high. Reads still pass, and both busy outputs stay high.
- R10: In master mode, the two write grants are never both high for the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_l | input | 1 | Left port select |
| wr_l | input | 1 | Left port write strobe (1 = write, 0 = read) |
| addr_l | input | ADDR_W | Left port address |
| sel_r | input | 1 | Right port select |
| wr_r | input | 1 | Right port write strobe |
| addr_r | input | ADDR_W | Right port address |
| busy_in_l_n | input | 1 | Slave mode: active-low hold for left writes |
| busy_in_r_n | input | 1 | Slave mode: active-low hold for right writes |
| busy_l_n | output | 1 | Active-low busy to left port (master mode) |
| busy_r_n | output | 1 | Active-low busy to right port (master mode) |
| wr_go_l | output | 1 | Left write may commit this cycle |
| wr_go_r | output | 1 | Right write may commit this cycle |
| rd_go_l | output | 1 | Left read proceeds this cycle |
| rd_go_r | output | 1 | Right read proceeds this cycle |

## Verification
The arrival trackers and the owner register are the state to watch. A port whose arrival is recorded wrongly gives the ownership to the wrong side. That shows at once as a missing write grant on the first port and a granted write on the second. One cycle later it also shows as busy going low on the wrong side. If the owner register does not clear or does not hold, the fault shows in the cycle after the collision ends or in the cycle after it begins. In that cycle a busy flag stays low, or a blocked port suddenly gets its write grant. In slave mode every fault shows in the same cycle as the busy input.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int SIDES = 2;
endpackage

// File: rtl/dpca_arrival.sv
// Flags a port whose request is new this cycle: its select just rose,
// or its address moved while it stayed selected.
module dpca_arrival #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              fresh
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         sel_q  <= sel;
         addr_q <= addr;
      end
   end

   assign fresh = sel & (~sel_q | (addr != addr_q));
endmodule

// File: rtl/dpca_judge.sv
// Decides the owner of a contested address and keeps it while the
// collision lasts; the busy flags are the registered loss indications.
module dpca_judge
   import dpca_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_l,
   input  logic              sel_r,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic              fresh_l,
   input  logic              fresh_r,
   output logic              lose_l,
   output logic              lose_r,
   output logic              busy_l_n,
   output logic              busy_r_n
);
   owner_e owner_q, owner_d, pick, win_now;
   logic   collide;

   assign collide = sel_l & sel_r & (addr_l == addr_r);

   always_comb begin
      // Only the left arriving late hands the location to the right;
      // a same-cycle tie falls to the left.
      if (fresh_l && !fresh_r) pick = OWN_RIGHT;
      else                     pick = OWN_LEFT;
      win_now = (owner_q == OWN_NONE) ? pick : owner_q;
      owner_d = collide ? win_now : OWN_NONE;
   end

   assign lose_l = collide & (win_now == OWN_RIGHT);
   assign lose_r = collide & (win_now == OWN_LEFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q  <= OWN_NONE;
         busy_l_n <= 1'b1;
         busy_r_n <= 1'b1;
      end else begin
         owner_q  <= owner_d;
         busy_l_n <= ~lose_l;
         busy_r_n <= ~lose_r;
      end
   end
endmodule

// File: rtl/dpca_gate.sv
// Per-port access qualification: a write needs the hold released,
// a read always passes.
module dpca_gate (
   input  logic sel,
   input  logic wr,
   input  logic hold,
   output logic wr_go,
   output logic rd_go
);
   assign wr_go = sel & wr & ~hold;
   assign rd_go = sel & ~wr;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
   import dpca_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter bit MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_l,
   input  logic              wr_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic              sel_r,
   input  logic              wr_r,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic              busy_in_l_n,
   input  logic              busy_in_r_n,
   output logic              busy_l_n,
   output logic              busy_r_n,
   output logic              wr_go_l,
   output logic              wr_go_r,
   output logic              rd_go_l,
   output logic              rd_go_r
);
   localparam int AW_MAX = 32;

   if (ADDR_W < 1 || ADDR_W > AW_MAX) begin : g_bad_width
      $error("dp_collide_arb: ADDR_W must lie in 1..%0d", AW_MAX);
   end

   logic [SIDES-1:0] sel_v, wr_v, hold_v, wr_go_v, rd_go_v;

   assign sel_v = {sel_r, sel_l};
   assign wr_v  = {wr_r, wr_l};

   for (genvar s = 0; s < SIDES; s++) begin : g_port
      dpca_gate u_gate (
         .sel   (sel_v[s]),
         .wr    (wr_v[s]),
         .hold  (hold_v[s]),
         .wr_go (wr_go_v[s]),
         .rd_go (rd_go_v[s])
      );
   end

   assign wr_go_l = wr_go_v[0];
   assign wr_go_r = wr_go_v[1];
   assign rd_go_l = rd_go_v[0];
   assign rd_go_r = rd_go_v[1];

   if (MASTER) begin : g_master
      logic [ADDR_W-1:0] addr_v [SIDES];
      logic [SIDES-1:0]  fresh_v;
      logic              lose_l, lose_r;
      logic              unused_slave_pins;

      assign addr_v[0] = addr_l;
      assign addr_v[1] = addr_r;
      assign unused_slave_pins = busy_in_l_n ^ busy_in_r_n;

      for (genvar s = 0; s < SIDES; s++) begin : g_arr
         dpca_arrival #(.ADDR_W(ADDR_W)) u_arr (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_v[s]),
            .addr  (addr_v[s]),
            .fresh (fresh_v[s])
         );
      end

      dpca_judge #(.ADDR_W(ADDR_W)) u_judge (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_l    (sel_l),
         .sel_r    (sel_r),
         .addr_l   (addr_l),
         .addr_r   (addr_r),
         .fresh_l  (fresh_v[0]),
         .fresh_r  (fresh_v[1]),
         .lose_l   (lose_l),
         .lose_r   (lose_r),
         .busy_l_n (busy_l_n),
         .busy_r_n (busy_r_n)
      );

      assign hold_v = {lose_r, lose_l};
   end else begin : g_slave
      logic unused_master_pins;

      assign unused_master_pins = clk ^ rst_n ^ (^addr_l) ^ (^addr_r);
      assign hold_v   = ~{busy_in_r_n, busy_in_l_n};
      assign busy_l_n = 1'b1;
      assign busy_r_n = 1'b1;
   end
endmodule

// File: rtl/dpca_chk.sv
module dpca_chk #(
   parameter int ADDR_W = 13,
   parameter bit MASTER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_l,
   input logic              wr_l,
   input logic [ADDR_W-1:0] addr_l,
   input logic              sel_r,
   input logic              wr_r,
   input logic [ADDR_W-1:0] addr_r,
   input logic              busy_in_l_n,
   input logic              busy_in_r_n,
   input logic              busy_l_n,
   input logic              busy_r_n,
   input logic              wr_go_l,
   input logic              wr_go_r,
   input logic              rd_go_l,
   input logic              rd_go_r
);
   // R8
   read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_l && !wr_l) |-> rd_go_l);

   // R8
   read_pass_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_r && !wr_r) |-> rd_go_r);

   if (MASTER) begin : g_m
      // R10
      no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_go_l && wr_go_r && addr_l == addr_r));

      // R6
      busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(!busy_l_n && !busy_r_n));

      // R6
      busy_l_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_l_n |-> $past(sel_l && sel_r && addr_l == addr_r));

      // R6
      busy_r_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_r_n |-> $past(sel_l && sel_r && addr_l == addr_r));

      // R2
      collide_one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_l && wr_l && sel_r && wr_r && addr_l == addr_r)
            |-> $countones({wr_go_l, wr_go_r}) == 1);
   end else begin : g_s
      // R9
      slave_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_in_l_n |-> !wr_go_l);

      // R9
      slave_block_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_in_r_n |-> !wr_go_r);

      // R9
      slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         busy_l_n && busy_r_n);
   end
endmodule

bind dp_collide_arb dpca_chk #(.ADDR_W(ADDR_W), .MASTER(MASTER)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_l       (sel_l),
   .wr_l        (wr_l),
   .addr_l      (addr_l),
   .sel_r       (sel_r),
   .wr_r        (wr_r),
   .addr_r      (addr_r),
   .busy_in_l_n (busy_in_l_n),
   .busy_in_r_n (busy_in_r_n),
   .busy_l_n    (busy_l_n),
   .busy_r_n    (busy_r_n),
   .wr_go_l     (wr_go_l),
   .wr_go_r     (wr_go_r),
   .rd_go_l     (rd_go_l),
   .rd_go_r     (rd_go_r)
);

// File: tb/dp_collide_arb_tb_top.sv
module dp_collide_arb_tb_top;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 13;
   localparam int NVEC   = 19;

   // sel_l wr_l addr_l sel_r wr_r addr_r | grant l,r | read l,r | busy l,r | tie
   typedef struct packed {
      logic       sl, wl;
      logic [3:0] al;
      logic       sr, wr;
      logic [3:0] ar;
      logic       gl, gr, rl, rr, bl, br;
      logic [1:0] t;   // t[0]: grants may fall either way; t[1]: busy either way
   } vec_t;

   localparam logic [19:0] VECS [NVEC] = '{
      20'b0_0_0000_0_0_0000_00_00_00_00,  // idle
      20'b1_1_0101_0_0_0000_10_00_00_00,  // left writes alone
      20'b1_1_0101_1_1_0101_10_00_00_00,  // R4 right raises select on 5
      20'b1_1_0101_1_1_0101_10_00_01_00,  // R5/R6 held, right busy
      20'b0_0_0101_1_1_0101_01_00_01_00,  // R6 left leaves, busy lingers
      20'b0_0_0101_1_1_0101_01_00_00_00,  // R6 busy released
      20'b1_0_0101_1_1_0101_01_10_00_00,  // R4/R8 left reads, loses
      20'b1_1_0101_1_1_0101_01_00_10_00,  // R5 left starts write, blocked
      20'b1_1_0101_1_1_1001_11_00_10_00,  // right moves away
      20'b1_1_0101_1_1_0101_10_00_00_00,  // R3 right moves onto 5, loses
      20'b0_0_0000_0_0_0000_00_00_01_00,
      20'b0_0_0000_0_0_0000_00_00_00_00,
      20'b1_1_0011_1_1_0011_00_00_00_01,  // R7 tie
      20'b1_1_0011_1_1_0011_00_00_00_11,
      20'b0_0_0000_0_0_0000_00_00_00_10,
      20'b0_0_0000_0_0_0000_00_00_00_00,
      20'b1_0_0111_1_0_0111_00_11_00_00,  // R8 both read same address
      20'b0_0_0000_0_0_0000_00_00_00_10,
      20'b0_0_0000_0_0_0000_00_00_00_00
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_l = 0, wr_l = 0, sel_r = 0, wr_r = 0;
   logic [ADDR_W-1:0] addr_l = '0, addr_r = '0;
   logic bin_l_n = 1'b1, bin_r_n = 1'b1;
   logic m_bl_n, m_br_n, m_gl, m_gr, m_rl, m_rr;
   logic s_bl_n, s_br_n, s_gl, s_gr, s_rl, s_rr;
   int   checks = 0, failures = 0;
   bit   done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dp_collide_arb #(.ADDR_W(ADDR_W), .MASTER(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .sel_l(sel_l), .wr_l(wr_l), .addr_l(addr_l),
      .sel_r(sel_r), .wr_r(wr_r), .addr_r(addr_r),
      .busy_in_l_n(bin_l_n), .busy_in_r_n(bin_r_n),
      .busy_l_n(m_bl_n), .busy_r_n(m_br_n),
      .wr_go_l(m_gl), .wr_go_r(m_gr), .rd_go_l(m_rl), .rd_go_r(m_rr)
   );

   dp_collide_arb #(.ADDR_W(ADDR_W), .MASTER(1'b0)) slv_i (
      .clk(clk), .rst_n(rst_n),
      .sel_l(sel_l), .wr_l(wr_l), .addr_l(addr_l),
      .sel_r(sel_r), .wr_r(wr_r), .addr_r(addr_r),
      .busy_in_l_n(bin_l_n), .busy_in_r_n(bin_r_n),
      .busy_l_n(s_bl_n), .busy_r_n(s_br_n),
      .wr_go_l(s_gl), .wr_go_r(s_gr), .rd_go_l(s_rl), .rd_go_r(s_rr)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic sl, wl, input logic [3:0] al,
                        input logic sr, wr, input logic [3:0] ar);
      sel_l = sl; wr_l = wl; addr_l = {{(ADDR_W-4){1'b0}}, al};
      sel_r = sr; wr_r = wr; addr_r = {{(ADDR_W-4){1'b0}}, ar};
   endtask

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      #1;
      check("R1 busy_l_n in reset", m_bl_n, 1);
      check("R1 busy_r_n in reset", m_br_n, 1);
      check("R1 no grant idle", m_gl + m_gr, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk, master instance
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VECS[i];
         @(negedge clk);
         drive(v.sl, v.wl, v.al, v.sr, v.wr, v.ar);
         #1;
         if (v.t[0]) check($sformatf("R7 one grant row %0d", i), m_gl + m_gr, 1);
         else begin
            check($sformatf("R2/R3/R4/R5 grant_l row %0d", i), m_gl, v.gl);
            check($sformatf("R2/R3/R4/R5 grant_r row %0d", i), m_gr, v.gr);
         end
         check($sformatf("R8 read_l row %0d", i), m_rl, v.rl);
         check($sformatf("R8 read_r row %0d", i), m_rr, v.rr);
         if (v.t[1]) check($sformatf("R6/R7 one busy row %0d", i), int'(!m_bl_n) + int'(!m_br_n), 1);
         else begin
            check($sformatf("R6 busy_l row %0d", i), int'(!m_bl_n), v.bl);
            check($sformatf("R6 busy_r row %0d", i), int'(!m_br_n), v.br);
         end
      end

      // R1 reset in the middle of a collision clears busy at once
      @(negedge clk); drive(1, 1, 4'd6, 0, 0, 4'd0);
      @(negedge clk); drive(1, 1, 4'd6, 1, 1, 4'd6);
      @(negedge clk); #1;
      check("R6 busy_r before reset", m_br_n, 0);
      rst_n = 1'b0; #1;
      check("R1 async reset clears busy_r", m_br_n, 1);
      @(negedge clk); drive(0, 0, 4'd0, 0, 0, 4'd0);
      rst_n = 1'b1;

      // R9 slave instance: busy input holds writes, reads pass
      @(negedge clk);
      bin_l_n = 1'b0; bin_r_n = 1'b0;
      drive(1, 1, 4'd2, 1, 0, 4'd2);
      #1;
      check("R9 slave write_l held", s_gl, 0);
      check("R9 slave read_r passes", s_rr, 1);
      @(negedge clk); #1;
      check("R9 slave busy outs high", int'(s_bl_n) + int'(s_br_n), 2);
      check("R9 slave write_l still held", s_gl, 0);
      @(negedge clk);
      bin_l_n = 1'b1;
      #1;
      check("R9 slave write_l released", s_gl, 1);
      @(negedge clk);
      drive(0, 0, 4'd0, 1, 1, 4'd2);
      #1;
      check("R9 slave write_r held", s_gr, 0);
      bin_r_n = 1'b1; #1;
      check("R9 slave write_r released", s_gr, 1);

      @(negedge clk); drive(0, 0, 4'd0, 0, 0, 4'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule